// File: doc/BRIEF.md
# Programmable Periodic Interrupt Divider

This block divides a 32.768 kHz timebase, delivered as a one-cycle tick enable in the system clock domain, into periodic interrupt events. A 4-bit rate code selects a power-of-two period. A free-running tick counter runs at all times. An event fires on the tick that brings this counter onto a multiple of the selected period. Events therefore stay on a fixed grid and do not depend on when the block was enabled.

Two enables gate the event. The interrupt enable makes each event set the interrupt-request and periodic flags of an 8-bit status word and raise the interrupt line. The pulse enable makes each event emit a single one-cycle pulse on a separate output. This pulse is not a square wave. A clear input models the read-to-clear of the status word.

Top module: `periodic_irq_div`

## Requirements
- R1: While `rst_ni` is low and on release, `event_o`, `pulse_o`, `irq_o` and `status_o` are all 0, and the tick counter restarts from 0.
- R2: For rate codes 3 to 15 the period is 2^(code-1) ticks. Code 3 gives 4 ticks and code 15 gives 16384 ticks. An event fires on the tick after which the free-running tick count (mod 2^15) is a multiple of the period. `event_o` is high in the cycle after that tick.
- R3: Rate code 1 behaves exactly like code 8, giving 128 ticks. Rate code 2 behaves exactly like code 9, giving 256 ticks.
- R4: No event fires when the rate code is 0. No event fires when both `irq_en_i` and `pulse_en_i` are 0.
- R5: The tick counter advances on every tick whether or not the timer runs. After enabling, the first event lands on the next multiple of the period, not one full period after the enable.
- R6: With `irq_en_i` set, an event sets `status_o[7]` (interrupt request) and `status_o[6]` (periodic) in the same cycle that `event_o` is high, and `irq_o` follows `status_o[7]`. `status_o[5:0]` are always 0.
- R7: With `pulse_en_i` set, `pulse_o` is high for exactly the event cycle. With `pulse_en_i` clear, `pulse_o` stays 0 even when events fire.
- R8: With `irq_en_i` clear and `pulse_en_i` set, events still appear on `event_o`. The status flags and `irq_o` are left unchanged.
- R9: `clr_i` clears `status_o` and `irq_o` on the next edge. A flag-setting event in the same cycle takes precedence, and the flags then read 0xC0.
- R10: `event_o` and `pulse_o` never stay high for two consecutive cycles. A change of rate code or enables is used from the next tick on, without an extra event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle 32.768 kHz tick enable |
| rate_i | input | 4 | Rate code, 0 disables |
| irq_en_i | input | 1 | Periodic interrupt enable |
| pulse_en_i | input | 1 | Pulse output enable |
| clr_i | input | 1 | Clear status flags and interrupt |
| event_o | output | 1 | One-cycle periodic event |
| pulse_o | output | 1 | One-cycle pulse per event when enabled |
| irq_o | output | 1 | Interrupt request level |
| status_o | output | 8 | Status flags: bit 7 request, bit 6 periodic |

## Verification
The assertions relate each event to the tick, rate code and enables sampled at the previous edge. They therefore assume that the inputs are stable around the clock edge and that `tick_i` is a one-cycle enable. The stimulus changes inputs only on the falling edge. It draws rate codes, enables, tick gaps and clears at random, and holds each setting for long segments so that many events fall under each code. Directed runs cover the longest period with a tick in every cycle, the aliased codes, an enable that arrives mid-period, and a clear that coincides with an event.

// File: rtl/pid_pkg.sv
package pid_pkg;
  localparam int unsigned RATE_W = 4;

  typedef struct packed {
    logic req;
    logic per;
  } pid_flags_t;

  // low codes reuse slower settings
  function automatic logic [RATE_W-1:0] eff_code(input logic [RATE_W-1:0] code);
    logic [RATE_W-1:0] e;
    e = code;
    if (code == RATE_W'(1)) e = RATE_W'(8);
    else if (code == RATE_W'(2)) e = RATE_W'(9);
    return e;
  endfunction
endpackage

// File: rtl/pid_rate_dec.sv
module pid_rate_dec
  import pid_pkg::*;
#(
  parameter int unsigned CNT_W = 15
) (
  input  logic [RATE_W-1:0] rate_i,
  output logic              valid_o,
  output logic [CNT_W-1:0]  mask_o
);
  logic [RATE_W-1:0] eff;

  assign eff     = eff_code(rate_i);
  assign valid_o = (rate_i != '0);

  // mask = period - 1, period = 2^(eff-1)
  for (genvar b = 0; b < CNT_W; b++) begin : g_mask
    assign mask_o[b] = (32'(eff) > (b + 1));
  end
endmodule

// File: rtl/pid_phase_cnt.sv
module pid_phase_cnt #(
  parameter int unsigned CNT_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_nxt_o
);
  logic [CNT_W-1:0] cnt_q;

  assign cnt_nxt_o = cnt_q + CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_nxt_o;
  end
endmodule

// File: rtl/pid_event_gen.sv
module pid_event_gen #(
  parameter int unsigned CNT_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             valid_i,
  input  logic [CNT_W-1:0] mask_i,
  input  logic [CNT_W-1:0] cnt_nxt_i,
  input  logic             irq_en_i,
  input  logic             pulse_en_i,
  output logic             fire_o,
  output logic             event_o,
  output logic             pulse_o
);
  logic run;
  logic event_q, pulse_q;

  assign run    = valid_i && (irq_en_i || pulse_en_i);
  assign fire_o = tick_i && run && ((cnt_nxt_i & mask_i) == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      event_q <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      event_q <= fire_o;
      pulse_q <= fire_o && pulse_en_i;
    end
  end

  assign event_o = event_q;
  assign pulse_o = pulse_q;
endmodule

// File: rtl/pid_flags.sv
module pid_flags
  import pid_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       fire_i,
  input  logic       irq_en_i,
  input  logic       clr_i,
  output logic [7:0] status_o,
  output logic       irq_o
);
  pid_flags_t flags_q, flags_d;

  always_comb begin
    flags_d = flags_q;
    if (clr_i) flags_d = '0;
    if (fire_i && irq_en_i) flags_d = '{req: 1'b1, per: 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= flags_d;
  end

  assign status_o = {flags_q.req, flags_q.per, 6'b0};
  assign irq_o    = flags_q.req;
endmodule

// File: rtl/periodic_irq_div.sv
module periodic_irq_div
  import pid_pkg::*;
#(
  parameter int unsigned CNT_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              irq_en_i,
  input  logic              pulse_en_i,
  input  logic              clr_i,
  output logic              event_o,
  output logic              pulse_o,
  output logic              irq_o,
  output logic [7:0]        status_o
);
  logic             valid;
  logic [CNT_W-1:0] mask;
  logic [CNT_W-1:0] cnt_nxt;
  logic             fire;

  pid_rate_dec #(.CNT_W(CNT_W)) u_dec (
    .rate_i (rate_i),
    .valid_o(valid),
    .mask_o (mask)
  );

  pid_phase_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .cnt_nxt_o(cnt_nxt)
  );

  pid_event_gen #(.CNT_W(CNT_W)) u_evt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .valid_i   (valid),
    .mask_i    (mask),
    .cnt_nxt_i (cnt_nxt),
    .irq_en_i  (irq_en_i),
    .pulse_en_i(pulse_en_i),
    .fire_o    (fire),
    .event_o   (event_o),
    .pulse_o   (pulse_o)
  );

  pid_flags u_flg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fire_i  (fire),
    .irq_en_i(irq_en_i),
    .clr_i   (clr_i),
    .status_o(status_o),
    .irq_o   (irq_o)
  );
endmodule

// File: rtl/pid_checker.sv
module pid_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic [3:0] rate_i,
  input logic       irq_en_i,
  input logic       pulse_en_i,
  input logic       clr_i,
  input logic       event_o,
  input logic       pulse_o,
  input logic       irq_o,
  input logic [7:0] status_o
);
  a_r2_event_needs_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_o |-> $past(tick_i));

  a_r4_code_zero_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rate_i == 4'd0) |-> !event_o);

  a_r4_no_enable_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!irq_en_i && !pulse_en_i) |-> !event_o);

  a_r6_flags_on_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_o && $past(irq_en_i)) |-> (status_o == 8'hC0 && irq_o));

  a_r6_low_bits_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[5:0] == 6'd0);

  a_r7_pulse_with_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |-> (event_o && $past(pulse_en_i)));

  a_r8_flags_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_o && !$past(irq_en_i) && !$past(clr_i)) |-> $stable(status_o));

  a_r9_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(clr_i) && !(event_o && $past(irq_en_i))) |-> (status_o == 8'h00 && !irq_o));

  a_r10_event_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_o |=> !event_o);

  a_r10_pulse_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);
endmodule

bind periodic_irq_div pid_checker u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .rate_i    (rate_i),
  .irq_en_i  (irq_en_i),
  .pulse_en_i(pulse_en_i),
  .clr_i     (clr_i),
  .event_o   (event_o),
  .pulse_o   (pulse_o),
  .irq_o     (irq_o),
  .status_o  (status_o)
);

// File: tb/periodic_irq_div_tb.sv
module periodic_irq_div_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic [3:0] rate_i = 4'd0;
  logic       irq_en_i = 1'b0;
  logic       pulse_en_i = 1'b0;
  logic       clr_i = 1'b0;
  logic       event_o, pulse_o, irq_o;
  logic [7:0] status_o;

  always #2.5 clk = ~clk;

  periodic_irq_div u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .rate_i(rate_i),
    .irq_en_i(irq_en_i), .pulse_en_i(pulse_en_i), .clr_i(clr_i),
    .event_o(event_o), .pulse_o(pulse_o), .irq_o(irq_o), .status_o(status_o)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int unsigned mcnt = 0;
  bit m_ev, m_pl;
  logic [7:0] m_st = 8'h00;

  function automatic int unsigned period_of(logic [3:0] c);
    int unsigned e;
    if (c == 0) return 0;
    e = (c == 1) ? 8 : (c == 2) ? 9 : int'(c);
    return 1 << (e - 1);
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(bit t, logic [3:0] r, bit p, bit s, bit c, string tag);
    bit fire;
    int unsigned per;
    tick_i = t; rate_i = r; irq_en_i = p; pulse_en_i = s; clr_i = c;
    per = period_of(r);
    if (t) mcnt = (mcnt + 1) % 32768;
    fire = t && (per != 0) && (p || s) && ((mcnt % per) == 0);
    m_ev = fire;
    m_pl = fire && s;
    if (c) m_st = 8'h00;
    if (fire && p) m_st = 8'hC0;
    @(posedge clk);
    @(negedge clk);
    chk(tag, "event_o", int'(event_o), int'(m_ev));
    chk(tag, "pulse_o", int'(pulse_o), int'(m_pl));
    chk(tag, "status_o", int'(status_o), int'(m_st));
    chk(tag, "irq_o", int'(irq_o), int'(m_st[7]));
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int gap;
    void'($urandom(32'h5eed));
    // R1 reset state, inputs active during reset
    tick_i = 1; rate_i = 4'd3; irq_en_i = 1; pulse_en_i = 1;
    repeat (3) @(negedge clk);
    chk("R1", "event_o", int'(event_o), 0);
    chk("R1", "pulse_o", int'(pulse_o), 0);
    chk("R1", "status_o", int'(status_o), 0);
    chk("R1", "irq_o", int'(irq_o), 0);
    tick_i = 0; rate_i = 0; irq_en_i = 0; pulse_en_i = 0;
    rst_ni = 1;
    @(negedge clk);

    // R2 fastest code, tick every cycle (R10 single-cycle pulses)
    for (int i = 0; i < 40; i++) step(1, 4'd3, 1, 1, (i % 5) == 4, "R10");

    // R4 code 0 and no enables: nothing happens while counter runs
    for (int i = 0; i < 60; i++) step(1, 4'd0, 1, 1, 1, "R4");
    for (int i = 0; i < 60; i++) step(1, 4'd4, 0, 0, 0, "R4");

    // R5 enable mid-period: count ticks to first event
    begin
      int n;
      int unsigned start;
      start = mcnt;
      n = 0;
      do begin
        step(1, 4'd6, 1, 0, 0, "R5");
        n++;
      end while (!event_o && n < 100);
      chk("R5", "ticks to first event", n, int'(32 - (start % 32)));
    end

    // R3 aliased codes: spacing of events
    for (int c = 1; c <= 2; c++) begin
      int n;
      n = 0;
      do step(1, 4'(c), 0, 1, 0, "R3"); while (!event_o);
      do begin
        step(1, 4'(c), 0, 1, 0, "R3");
        n++;
      end while (!event_o);
      chk("R3", "alias spacing", n, (c == 1) ? 128 : 256);
    end

    // R8 pulse only, flags untouched
    step(1, 4'd3, 0, 0, 1, "R9");
    for (int i = 0; i < 50; i++) step(1, 4'd3, 0, 1, 0, "R8");

    // R9 clear coinciding with event: set wins
    while ((mcnt + 1) % 4 != 0) step(1, 4'd3, 1, 0, 0, "R9");
    step(1, 4'd3, 1, 0, 1, "R9");
    chk("R9", "set wins status", int'(status_o), 8'hC0);
    step(0, 4'd3, 1, 0, 1, "R9");

    // R7 irq only, no pulse; then rate change on the fly
    for (int i = 0; i < 80; i++) step(i % 2, 4'd4, 1, 0, i % 9 == 0, "R7");
    for (int i = 0; i < 80; i++) step(1, (i < 40) ? 4'd5 : 4'd3, 1, 1, 0, "R10");

    // R2 slowest code over a full counter wrap
    for (int i = 0; i < 33000; i++) step(1, 4'd15, 1, 1, (i % 1000) == 0, "R2");

    // random mix
    for (int seg = 0; seg < 60; seg++) begin
      logic [3:0] r;
      bit p, s;
      r = ($urandom_range(0, 7) == 0) ? 4'($urandom_range(10, 15)) : 4'($urandom_range(0, 9));
      p = 1'($urandom_range(0, 1));
      s = 1'($urandom_range(0, 1));
      gap = $urandom_range(0, 2);
      for (int i = 0; i < 250; i++)
        step(($urandom_range(0, gap) == 0), r, p, s, ($urandom_range(0, 15) == 0), "R2");
    end

    summary();
    $finish;
  end
endmodule